// File: doc/BRIEF.md
# Receive Pair Polarity Detector

This block decides whether the receive twisted pair of a 10BASE-T port has its wires swapped. It sees nothing of the analog signal. An upstream pulse qualifier hands it one-cycle strobes: one for each single normal link pulse (NLP) and one for each complete fast link pulse (FLP) burst. Each strobe comes with a flag that says whether the pulse or burst looked inverted.

The polarity flags describe what the qualifier sees *after* the correction that this block currently applies. Once the block has declared reversal and inverts the receive path, a pair that really is reversed looks normal, and a pair that has since been fixed looks inverted. One rule therefore works in both directions:
- eight inverted-looking normal link pulses in a row toggle the decision;
- one inverted-looking burst also toggles it.

This gives the same hysteresis for setting and for clearing.

The surrounding logic can switch automatic detection off. In that mode the receive correction is released and a manual invert input alone sets the transmitter polarity and the reported status. Loss of link wipes the decision and the pulse count.

Top module: `rx_pol_detect`

## Requirements
- R1: While reset is asserted and right after it, the reversal state is 0 and the pulse count is empty. With detection enabled, rev_stat_o, rx_inv_o and tx_inv_o are all 0.
- R2: With link up and detection enabled, the reversal state toggles on the clock edge that samples the eighth consecutive strobe with nlp_vld_i=1 and nlp_inv_i=1. Seven such strobes leave the state unchanged. Cycles without a strobe neither advance nor clear the count.
- R3: A normal link pulse strobe with nlp_inv_i=0, or any burst strobe, restarts the inverted-pulse count from zero.
- R4: A burst strobe with flp_vld_i=1 and flp_inv_i=1 toggles the reversal state on the edge that samples it, whatever the pulse count.
- R5: The polarity flags are relative to the present correction. Once the state is 1, the same rules (eight inverted-looking pulses, or one inverted-looking burst) return it to 0.
- R6: While link_ok_i is 0, the count and the reversal state are cleared on every edge and all strobes are ignored.
- R7: With auto_dis_i=0, rx_inv_o and rev_stat_o equal the reversal state and tx_inv_o is 0. With auto_dis_i=1, rx_inv_o is 0 and both tx_inv_o and rev_stat_o equal man_inv_i, all without a clock delay.
- R8: While auto_dis_i is 1, the count and the reversal state are cleared on every edge. After detection is re-enabled it starts from the non-reversed state with an empty count.
- R9: When burst and normal pulse strobes arrive in the same cycle, the burst alone decides the outcome and the normal pulse is discarded, so the count is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| nlp_vld_i | input | 1 | One-cycle strobe: a normal link pulse was qualified |
| nlp_inv_i | input | 1 | With nlp_vld_i: 1 = pulse looked inverted |
| flp_vld_i | input | 1 | One-cycle strobe: a fast link pulse burst was qualified |
| flp_inv_i | input | 1 | With flp_vld_i: 1 = burst looked inverted |
| link_ok_i | input | 1 | 1 while the link is up |
| auto_dis_i | input | 1 | 1 = automatic polarity detection and correction off |
| man_inv_i | input | 1 | Manual transmit-invert value used while detection is off |
| rev_stat_o | output | 1 | Reversal status (manual value while detection is off) |
| rx_inv_o | output | 1 | Invert the receive path |
| tx_inv_o | output | 1 | Invert the transmit path |

## Verification
The bench goes after these corner cases:
- **Count length.** Runs of seven and eight inverted pulses are checked. A counter that is one step off would toggle a pulse early or late.
- **Consecutive runs.** A run broken by one correct pulse or by a burst is checked. A design that only counted totals would declare reversal on scattered inverted pulses.
- **Clearing.** The state is cleared through the same relative-polarity rule, which would catch a one-way latch that can never recover.
- **Simultaneous strobes.** Burst and pulse strobes arrive together. A design that let the pulse advance the count would declare reversal one pulse early later on.
- **Mode switches.** Enabling and disabling, and dropping the link, happen partway through a run. A design that kept stale count or state would toggle after fewer than eight fresh pulses or come back already reversed.

// File: rtl/rx_pol_pkg.sv
package rx_pol_pkg;

  // Decoded per-cycle event seen by the polarity decision.
  typedef enum logic [2:0] {
    EV_IDLE      = 3'd0,
    EV_FLUSH     = 3'd1,
    EV_RUN_OK    = 3'd2,
    EV_RUN_INV   = 3'd3,
    EV_BURST_OK  = 3'd4,
    EV_BURST_INV = 3'd5
  } pol_ev_e;

endpackage

// File: rtl/pol_run_counter.sv
module pol_run_counter #(
  parameter int LIMIT = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // The hit strobe wraps the count back to zero.
  assign hit_o  = inc_i && (cnt_q == LAST);
  assign cnt_en = clr_i || inc_i;

  always_comb begin
    if (clr_i || hit_o) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pol_state_reg.sv
module pol_state_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tgl_i,
  output logic state_o
);

  logic st_q, st_d, st_en;

  assign st_en = clr_i || tgl_i;

  always_comb begin
    if (clr_i) st_d = 1'b0;
    else       st_d = ~st_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= 1'b0;
    else if (st_en) st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/rx_pol_detect.sv
module rx_pol_detect
  import rx_pol_pkg::*;
#(
  parameter int INV_LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nlp_vld_i,
  input  logic nlp_inv_i,
  input  logic flp_vld_i,
  input  logic flp_inv_i,
  input  logic link_ok_i,
  input  logic auto_dis_i,
  input  logic man_inv_i,
  output logic rev_stat_o,
  output logic rx_inv_o,
  output logic tx_inv_o
);

  localparam int CNT_W = (INV_LIMIT > 1) ? $clog2(INV_LIMIT) : 1;

  pol_ev_e          ev;
  logic             cnt_clr, cnt_inc, run_hit;
  logic             st_clr, st_tgl, rev_state;
  logic [CNT_W-1:0] run_cnt;

  // Event decode: flush beats bursts, bursts beat single pulses.
  always_comb begin
    if (!link_ok_i || auto_dis_i) ev = EV_FLUSH;
    else if (flp_vld_i)           ev = flp_inv_i ? EV_BURST_INV : EV_BURST_OK;
    else if (nlp_vld_i)           ev = nlp_inv_i ? EV_RUN_INV : EV_RUN_OK;
    else                          ev = EV_IDLE;
  end

  always_comb begin
    cnt_inc = (ev == EV_RUN_INV);
    cnt_clr = (ev == EV_FLUSH) || (ev == EV_RUN_OK) ||
              (ev == EV_BURST_OK) || (ev == EV_BURST_INV);
    st_clr  = (ev == EV_FLUSH);
    st_tgl  = (ev == EV_BURST_INV) || run_hit;
  end

  pol_run_counter #(
    .LIMIT (INV_LIMIT),
    .CNT_W (CNT_W)
  ) u_run_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .hit_o  (run_hit),
    .cnt_o  (run_cnt)
  );

  pol_state_reg u_rev_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_clr),
    .tgl_i   (st_tgl),
    .state_o (rev_state)
  );

  always_comb begin
    if (auto_dis_i) begin
      rx_inv_o   = 1'b0;
      tx_inv_o   = man_inv_i;
      rev_stat_o = man_inv_i;
    end else begin
      rx_inv_o   = rev_state;
      tx_inv_o   = 1'b0;
      rev_stat_o = rev_state;
    end
  end

endmodule

// File: rtl/rx_pol_detect_chk.sv
module rx_pol_detect_chk #(
  parameter int INV_LIMIT = 8,
  parameter int CNT_W     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             nlp_vld_i,
  input logic             flp_vld_i,
  input logic             flp_inv_i,
  input logic             link_ok_i,
  input logic             auto_dis_i,
  input logic             rx_inv_o,
  input logic             tx_inv_o,
  input logic [CNT_W-1:0] cnt_i
);

  // R2: the count never reaches the limit.
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_i) < INV_LIMIT);

  // R2: with no strobe, neither the count nor the decision moves.
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ok_i && !auto_dis_i && !nlp_vld_i && !flp_vld_i) |=>
      ((auto_dis_i || rx_inv_o == $past(rx_inv_o)) && cnt_i == $past(cnt_i)));

  // R4: an inverted-looking burst flips the receive correction.
  p_burst_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ok_i && !auto_dis_i && flp_vld_i && flp_inv_i) |=>
      (auto_dis_i || rx_inv_o != $past(rx_inv_o)));

  // R6: a link drop leaves nothing behind.
  p_link_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_ok_i |=> (!rx_inv_o && cnt_i == '0));

  // R7: transmit inversion only in manual mode.
  p_tx_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_dis_i |-> !tx_inv_o);

  // R8: re-enabling starts clean.
  p_reenable_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(auto_dis_i) |-> (!rx_inv_o && cnt_i == '0));

endmodule

bind rx_pol_detect rx_pol_detect_chk #(
  .INV_LIMIT (INV_LIMIT),
  .CNT_W     (CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nlp_vld_i  (nlp_vld_i),
  .flp_vld_i  (flp_vld_i),
  .flp_inv_i  (flp_inv_i),
  .link_ok_i  (link_ok_i),
  .auto_dis_i (auto_dis_i),
  .rx_inv_o   (rx_inv_o),
  .tx_inv_o   (tx_inv_o),
  .cnt_i      (run_cnt)
);

// File: tb/rx_pol_detect_tb_top.sv
`timescale 1ns/1ps
module rx_pol_detect_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  logic nlp_vld, nlp_inv, flp_vld, flp_inv, link_ok, auto_dis, man_inv;
  logic rev_stat, rx_inv, tx_inv;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // Reference model state
  int m_cnt  = 0;
  bit m_stat = 1'b0;

  always #4 clk = ~clk;

  rx_pol_detect dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .nlp_vld_i  (nlp_vld),
    .nlp_inv_i  (nlp_inv),
    .flp_vld_i  (flp_vld),
    .flp_inv_i  (flp_inv),
    .link_ok_i  (link_ok),
    .auto_dis_i (auto_dis),
    .man_inv_i  (man_inv),
    .rev_stat_o (rev_stat),
    .rx_inv_o   (rx_inv),
    .tx_inv_o   (tx_inv)
  );

  task automatic chk(input string tag, input bit act, input bit exp_v, input string what);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp_v, $time);
    end
  endtask

  task automatic cmp_model(input string tag);
    bit e_rx, e_tx, e_rs;
    e_rx = auto_dis ? 1'b0 : m_stat;
    e_tx = auto_dis ? man_inv : 1'b0;
    e_rs = auto_dis ? man_inv : m_stat;
    checks++;
    if (rx_inv !== e_rx || tx_inv !== e_tx || rev_stat !== e_rs) begin
      failures++;
      $display("FAIL %s rx/tx/stat actual=%0b%0b%0b expected=%0b%0b%0b at %0t",
               tag, rx_inv, tx_inv, rev_stat, e_rx, e_tx, e_rs, $time);
    end
  endtask

  task automatic model_update();
    if (!link_ok || auto_dis) begin
      m_cnt = 0; m_stat = 1'b0;
    end else if (flp_vld) begin
      m_cnt = 0;
      if (flp_inv) m_stat = !m_stat;
    end else if (nlp_vld) begin
      if (nlp_inv) begin
        m_cnt++;
        if (m_cnt == 8) begin m_stat = !m_stat; m_cnt = 0; end
      end else m_cnt = 0;
    end
  endtask

  // Drive one cycle, compare the outputs with the model, then advance the model at the edge.
  task automatic step(input bit nv, ni, fv, fi, lk, ad, mi, input string tag);
    @(negedge clk);
    nlp_vld = nv; nlp_inv = ni; flp_vld = fv; flp_inv = fi;
    link_ok = lk; auto_dis = ad; man_inv = mi;
    #1;
    cmp_model(tag);
    @(posedge clk);
    model_update();
  endtask

  task automatic nlp(input bit inv, input string tag);
    step(1, inv, 0, 0, 1, 0, 0, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 1, 0, 0, tag);
  endtask

  task automatic settle();
    @(negedge clk);
    nlp_vld = 0; flp_vld = 0; #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    nlp_vld = 0; nlp_inv = 0; flp_vld = 0; flp_inv = 0;
    link_ok = 1; auto_dis = 0; man_inv = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", rx_inv, 1'b0, "rx_inv in reset");
    chk("R1", rev_stat, 1'b0, "rev_stat in reset");
    chk("R1", tx_inv, 1'b0, "tx_inv in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: seven inverted pulses, with gaps, do not flip; the eighth does.
    for (int i = 0; i < 7; i++) begin nlp(1, "R2"); idle("R2"); end
    settle(); chk("R2", rx_inv, 1'b0, "after seven inverted pulses");
    nlp(1, "R2");
    settle(); chk("R2", rx_inv, 1'b1, "after eighth inverted pulse");
    chk("R7", rev_stat, 1'b1, "status follows state");

    // R5: inverted-looking pulses now clear it again.
    for (int i = 0; i < 7; i++) nlp(1, "R5");
    settle(); chk("R5", rx_inv, 1'b1, "seven clearing pulses");
    nlp(1, "R5");
    settle(); chk("R5", rx_inv, 1'b0, "cleared by eight pulses");

    // R3: a correct pulse breaks the run.
    for (int i = 0; i < 5; i++) nlp(1, "R3");
    nlp(0, "R3");
    for (int i = 0; i < 7; i++) nlp(1, "R3");
    settle(); chk("R3", rx_inv, 1'b0, "run broken by correct pulse");
    nlp(1, "R3");
    settle(); chk("R3", rx_inv, 1'b1, "fresh run of eight completes");

    // R3: a correct burst also breaks the run.
    for (int i = 0; i < 6; i++) nlp(1, "R3");
    step(0, 0, 1, 0, 1, 0, 0, "R3");
    for (int i = 0; i < 7; i++) nlp(1, "R3");
    settle(); chk("R3", rx_inv, 1'b1, "run broken by correct burst");
    nlp(1, "R3");
    settle(); chk("R3", rx_inv, 1'b0, "eighth after burst clears");

    // R4: one inverted burst sets, another clears.
    step(0, 0, 1, 1, 1, 0, 0, "R4");
    settle(); chk("R4", rx_inv, 1'b1, "burst sets reversal");
    step(0, 0, 1, 1, 1, 0, 0, "R4");
    settle(); chk("R4", rx_inv, 1'b0, "burst clears reversal");

    // R9: a simultaneous pulse is discarded and the run restarts.
    for (int i = 0; i < 7; i++) nlp(1, "R9");
    step(1, 1, 1, 0, 1, 0, 0, "R9");
    nlp(1, "R9");
    settle(); chk("R9", rx_inv, 1'b0, "pulse beside burst not counted");
    for (int i = 0; i < 6; i++) nlp(1, "R9");
    step(1, 1, 1, 1, 1, 0, 0, "R9");
    settle(); chk("R9", rx_inv, 1'b1, "burst decides joint strobe");

    // R6: link loss clears state and count; strobes ignored meanwhile.
    step(0, 0, 0, 0, 0, 0, 0, "R6");
    settle(); chk("R6", rx_inv, 1'b0, "link loss clears state");
    for (int i = 0; i < 5; i++) nlp(1, "R6");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 0, 0, 0, "R6");
    settle(); chk("R6", rx_inv, 1'b0, "strobes ignored while link down");
    for (int i = 0; i < 7; i++) nlp(1, "R6");
    settle(); chk("R6", rx_inv, 1'b0, "count restarted after link loss");
    nlp(1, "R6");
    settle(); chk("R6", rx_inv, 1'b1, "eight after link loss");

    // R7, R8: manual mode and clean re-enable.
    step(0, 0, 0, 0, 1, 1, 1, "R7");
    #1; chk("R7", rx_inv, 1'b0, "rx released when disabled");
    chk("R7", tx_inv, 1'b1, "tx follows manual");
    chk("R7", rev_stat, 1'b1, "status follows manual");
    step(1, 1, 1, 1, 1, 1, 0, "R7");
    #1; chk("R7", tx_inv, 1'b0, "tx follows manual low");
    for (int i = 0; i < 3; i++) nlp(1, "R8");
    step(0, 0, 0, 0, 1, 1, 0, "R8");
    settle(); chk("R8", rx_inv, 1'b0, "re-enable starts unreversed");
    for (int i = 0; i < 7; i++) nlp(1, "R8");
    settle(); chk("R8", rx_inv, 1'b0, "count empty after re-enable");
    nlp(1, "R8");
    settle(); chk("R8", rx_inv, 1'b1, "eight fresh pulses after re-enable");

    // Mixed random traffic against the model.
    begin
      bit ad = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 79) == 0) ad = !ad;
        step($urandom_range(0, 2) == 0, $urandom_range(0, 7) != 0,
             $urandom_range(0, 39) == 0, $urandom_range(0, 1) == 1,
             $urandom_range(0, 99) != 0, ad, $urandom_range(0, 1) == 1, "R5");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule